// File: doc/BRIEF.md
# Shutter Speed Code Register

This block holds the electronic-shutter setting that the exposure timing logic consumes. Three shared input lines carry the setting in one of two ways. In serial entry they act as a data line, a shift clock and a commit strobe: eight bits are shifted in, then the strobe copies them into the holding register. In parallel entry the same three lines form a 3-bit selector, and a fixed table turns it into an 8-bit load value. The consumer therefore sees one 8-bit code format in both modes.

All three shared lines are resynchronised to the system clock through two flops, and their edges are detected in that domain. For this reason each level on a line must last at least three system clocks. A setting is taken only when the discharge enable is high and the iris/shutter select is low, which means shutter operation. At any other time the holding register keeps its value and the shift register does not move. A larger load value means a longer exposure, and 00h is the shortest.

Top module: `shutter_code_reg`

## Requirements
- R1: After reset, `speed_code` is 00h and `par_mode` is 0.
- R2: In serial entry (`par_sel`=0), each rising edge of `line_b` shifts the level of `line_a` into the shift register. The first bit received ends up as bit 7 and the last as bit 0.
- R3: In serial entry, `speed_code` changes only on a rising edge of `line_c`, which copies the shift register into it. Shifting on its own leaves `speed_code` unchanged.
- R4: In parallel entry (`par_sel`=1), the selector is {line_a, line_b, line_c} with line_c as bit 0. Selectors 7..0 map to EDh, CAh, ACh, 9Ch, 87h, 6Ah, 4Eh, 00h. `speed_code` follows the selector while entry is accepted.
- R5: While `dis_en` is 0, strobes, shift clocks and parallel selectors have no effect on `speed_code` or on the shift register contents.
- R6: While `iris_sel` is 1, strobes, shift clocks and parallel selectors have no effect on `speed_code` or on the shift register contents.
- R7: If more than eight bits are shifted before a strobe, the strobe commits the last eight bits received.
- R8: `par_mode` shows `par_sel` one clock later. When entry switches from parallel to serial, `speed_code` keeps its last parallel value until the next strobe.
- R9: A strobe rising edge that is applied between clock edges appears on `speed_code` right after the third rising clock edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dis_en | input | 1 | Discharge enable; entry is accepted only when this is high |
| iris_sel | input | 1 | High selects iris operation; entry is accepted only when this is low |
| par_sel | input | 1 | Low selects serial entry, high selects parallel entry |
| line_a | input | 1 | Serial data, or parallel selector bit 2 |
| line_b | input | 1 | Serial shift clock, or parallel selector bit 1 |
| line_c | input | 1 | Serial commit strobe, or parallel selector bit 0 |
| speed_code | output | 8 | Held shutter load value |
| par_mode | output | 1 | Registered entry-mode flag |

## Verification
The hardest case to reach is a shift register that has moved while `speed_code` has not. This state exists only between shift clocks and a strobe, and the ports show it only after a later strobe. The bench builds it in three ways. It clocks in bits while entry is blocked and then commits with an enabled strobe alone. It shifts more than eight bits. It commits only after a return from parallel entry. Random bytes from a fixed seed are mixed with directed runs over all eight selectors.

// File: rtl/shutter_code_reg.sv
module shutter_code_reg #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dis_en,
  input  logic              iris_sel,
  input  logic              par_sel,
  input  logic              line_a,
  input  logic              line_b,
  input  logic              line_c,
  output logic [CODE_W-1:0] speed_code,
  output logic              par_mode
);
  localparam int LINES = 3;

  logic [LINES-1:0] meta_q, sync_q, prev_q;
  logic [CODE_W-1:0] shift_q, hold_q;
  logic par_q;

  function automatic logic [7:0] sel_to_code(input logic [2:0] s);
    case (s)
      3'd7:    sel_to_code = 8'hED;
      3'd6:    sel_to_code = 8'hCA;
      3'd5:    sel_to_code = 8'hAC;
      3'd4:    sel_to_code = 8'h9C;
      3'd3:    sel_to_code = 8'h87;
      3'd2:    sel_to_code = 8'h6A;
      3'd1:    sel_to_code = 8'h4E;
      default: sel_to_code = 8'h00;
    endcase
  endfunction

  wire accept   = dis_en & ~iris_sel;
  wire ser_ok   = accept & ~par_sel;
  wire par_ok   = accept & par_sel;
  wire dat_s    = sync_q[2];
  wire sclk_up  = sync_q[1] & ~prev_q[1];
  wire stb_up   = sync_q[0] & ~prev_q[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= {line_a, line_b, line_c};
      sync_q <= meta_q;
      prev_q <= sync_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      shift_q <= '0;
    else if (ser_ok && sclk_up)
      shift_q <= {shift_q[CODE_W-2:0], dat_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      hold_q <= '0;
    else if (par_ok)
      hold_q <= CODE_W'(sel_to_code(sync_q));
    else if (ser_ok && stb_up)
      hold_q <= shift_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) par_q <= 1'b0;
    else        par_q <= par_sel;

  assign speed_code = hold_q;
  assign par_mode   = par_q;

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_ok && sclk_up) |=> (shift_q[0] == $past(dat_s)));

  assert_commit_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_ok && !stb_up) |=> $stable(speed_code));

  assert_fastest_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    par_ok |=> ((speed_code == '0) == ($past(sync_q) == '0)));

  assert_blocked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_en |=> ($stable(speed_code) && $stable(shift_q)));

  assert_iris_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iris_sel |=> ($stable(speed_code) && $stable(shift_q)));
endmodule

// File: tb/test_shutter_code_reg.sv
module test_shutter_code_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dis_en = 1'b0, iris_sel = 1'b0, par_sel = 1'b0;
  logic line_a = 1'b0, line_b = 1'b0, line_c = 1'b0;
  logic [7:0] speed_code;
  logic par_mode;
  int checks = 0, errors = 0;
  logic [7:0] exp_sh = 8'h00, exp_hold = 8'h00;

  always #5 clk = ~clk;

  shutter_code_reg i_shutter_code_reg (
    .clk(clk), .rst_n(rst_n), .dis_en(dis_en), .iris_sel(iris_sel),
    .par_sel(par_sel), .line_a(line_a), .line_b(line_b), .line_c(line_c),
    .speed_code(speed_code), .par_mode(par_mode));

  function automatic logic [7:0] table_val(input int s);
    logic [7:0] t [8] = '{8'h00, 8'h4E, 8'h6A, 8'h87, 8'h9C, 8'hAC, 8'hCA, 8'hED};
    return t[s];
  endfunction

  function automatic bit open_now();
    return dis_en && !iris_sel;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    line_a = b; idle(4);
    line_b = 1'b1; idle(4);
    line_b = 1'b0; idle(4);
    if (open_now() && !par_sel) exp_sh = {exp_sh[6:0], b};
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic strobe();
    line_c = 1'b1; idle(4);
    line_c = 1'b0; idle(4);
    if (open_now() && !par_sel) exp_hold = exp_sh;
  endtask

  initial begin
    void'($urandom(32'd4711));
    idle(3);
    chk("R1 code", speed_code, 8'h00);
    chk("R1 mode", {7'd0, par_mode}, 8'h00);
    rst_n = 1'b1;
    dis_en = 1'b1;
    idle(3);

    for (int k = 0; k < 10; k++) begin
      logic [7:0] v = 8'($urandom);
      send_byte(v);
      chk("R3 no change before strobe", speed_code, exp_hold);
      strobe();
      chk("R2 serial byte", speed_code, v);
    end

    send_byte(8'h4E); send_byte(8'h9C); strobe();
    chk("R2 directed 9Ch", speed_code, 8'h9C);

    send_bit(1'b1); send_bit(1'b0);
    send_byte(8'hA5); strobe();
    chk("R7 last eight bits", speed_code, 8'hA5);

    send_byte(8'h3C);
    line_c = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 not yet after two edges", speed_code, 8'hA5);
    @(negedge clk);
    chk("R9 updated after third edge", speed_code, 8'h3C);
    exp_hold = 8'h3C;
    idle(2); line_c = 1'b0; idle(4);

    dis_en = 1'b0;
    send_byte(8'h11); strobe();
    chk("R5 disabled strobe ignored", speed_code, 8'h3C);
    dis_en = 1'b1;
    strobe();
    chk("R5 disabled shifts ignored", speed_code, 8'h3C);

    iris_sel = 1'b1;
    send_byte(8'h77); strobe();
    chk("R6 iris strobe ignored", speed_code, 8'h3C);
    iris_sel = 1'b0;
    strobe();
    chk("R6 iris shifts ignored", speed_code, 8'h3C);

    par_sel = 1'b1; idle(2);
    chk("R8 mode flag", {7'd0, par_mode}, 8'h01);
    for (int s = 0; s < 8; s++) begin
      {line_a, line_b, line_c} = 3'(s); idle(5);
      chk("R4 parallel table", speed_code, table_val(s));
    end
    for (int k = 0; k < 6; k++) begin
      int s = int'($urandom_range(7));
      {line_a, line_b, line_c} = 3'(s); idle(5);
      chk("R4 parallel random", speed_code, table_val(s));
    end
    exp_hold = speed_code;

    dis_en = 1'b0;
    {line_a, line_b, line_c} = 3'd2; idle(5);
    chk("R5 parallel ignored", speed_code, exp_hold);
    dis_en = 1'b1;
    {line_a, line_b, line_c} = 3'd6; idle(5);
    exp_hold = 8'hCA;
    chk("R4 code 6", speed_code, 8'hCA);

    par_sel = 1'b0; idle(2);
    {line_a, line_b, line_c} = 3'd0; idle(5);
    chk("R8 keeps parallel value", speed_code, 8'hCA);
    chk("R8 mode flag low", {7'd0, par_mode}, 8'h00);
    strobe();
    chk("R8 strobe commits serial", speed_code, exp_sh);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule